// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block sits between a group of interrupting devices and a processor core. Each device line can raise or withdraw a request. Each line carries a fixed 3-bit priority level and an interrupt vector. At each instruction boundary the arbiter compares the pending requests against the processor's current priority. When a request qualifies, the arbiter raises a take strobe in the same cycle and presents the winning vector and its level. It also acknowledges the winning device on a one-hot line.

Requests are held per source. A source keeps its place in arrival order until it is acknowledged or withdrawn. Edge-style sources drop their request when acknowledged. Level-style sources stay pending until the device withdraws them.

The arbiter also owns the processor priority field. Software can load it in two ways: with a status-word write, or with the set-priority instruction, which covers opcodes 0x98 to 0x9F. The arbiter tracks whether the processor is in its wait state. A waiting processor is re-examined on every cycle, and a taken interrupt wakes it.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset no request is pending, the processor priority is 0, the wait flag is clear, and take, wake and every acknowledge are low.
- R2: An interrupt is taken only in a cycle where `boundary` is high or the wait flag is set, and never while `cpu_halted` is high.
- R3: Only levels strictly greater than `cur_pri` are eligible. Among the eligible levels, the highest one that has a pending source wins.
- R4: Within one level, the source whose request became pending earliest is chosen first. Sources that become pending in the same cycle are ordered by ascending index.
- R5: A set pulse on a source that is already pending has no effect, and the source keeps its original place in the order.
- R6: A clear pulse withdraws a pending source from the next cycle on. When set and clear arrive together, clear wins.
- R7: On acknowledge, a source whose `irq_edge` bit is 1 stops pending from the next cycle. A source whose bit is 0 stays pending.
- R8: In the cycle of take, `take_vec` and `take_lvl` are the winner's vector and level, and `irq_ack` is one-hot on the winner. Outside take, `irq_ack` is zero.
- R9: An `op_valid` opcode with bits 15:3 equal to 0x13 (0x98 to 0x9F) loads `cur_pri` from opcode bits 2:0 in the next cycle. A `psw_wr` loads it from `psw_pri_wdata`, which carries status-word bits 7:5, and takes precedence over a same-cycle set-priority opcode.
- R10: `wait_req` sets the wait flag for the next cycle. A take clears the flag for the next cycle and wins over a same-cycle `wait_req`. `wake` is high exactly when an interrupt is taken while the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set | input | N_SRC | Per-source request pulse |
| irq_clr | input | N_SRC | Per-source withdraw pulse |
| irq_edge | input | N_SRC | 1 = source is cleared on acknowledge |
| irq_lvl | input | 3*N_SRC | Per-source priority level, packed |
| irq_vec | input | VEC_W*N_SRC | Per-source vector, packed |
| boundary | input | 1 | Instruction boundary strobe |
| cpu_halted | input | 1 | Processor halted, no interrupt evaluated |
| wait_req | input | 1 | Processor enters wait state |
| psw_wr | input | 1 | Status-word write strobe |
| psw_pri_wdata | input | 3 | Status-word bits 7:5 being written |
| op_valid | input | 1 | Executed opcode valid |
| opcode | input | 16 | Executed opcode |
| take | output | 1 | Interrupt taken this cycle |
| take_vec | output | VEC_W | Vector of the taken source |
| take_lvl | output | 3 | Level of the taken source |
| irq_ack | output | N_SRC | One-hot acknowledge to the winner |
| cur_pri | output | 3 | Current processor priority |
| waiting | output | 1 | Processor in wait state |
| wake | output | 1 | Take while waiting |

## Verification
The bench builds arrival-order ties on purpose. It makes two sources at one level become pending in the same cycle, and it re-asserts a source that is already pending. A design that broke the tie the wrong way, or let a repeat request move a source to the back, would then vector to the wrong device. It places a source exactly at the processor priority, which catches an off-by-one eligibility check that takes an interrupt it must hold off. It acknowledges level-style and edge-style sources back to back, where swapping the two would drop a level request early or take an edge request twice. It also fires a set-priority opcode together with a status-word write, and it holds a request in wait state below the priority and then lowers the priority. A wrong precedence, or a wait flag that ignores cycles without a boundary, shows up there as a wrong priority or a missing wake.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;
  // opcode bits 15:3 that select the set-priority instruction
  localparam logic [12:0] SETPRI_OP_HI = 13'h0013;

  typedef logic [LVL_W-1:0] lvl_t;

  function automatic logic is_setpri(input logic [15:0] op);
    return op[15:3] == SETPRI_OP_HI;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irq_pend_order.sv
module irq_pend_order #(
  parameter int N_SRC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SRC-1:0]            set_i,
  input  logic [N_SRC-1:0]            clr_i,
  input  logic [N_SRC-1:0]            ack_i,
  input  logic [N_SRC-1:0]            edge_i,
  output logic [N_SRC-1:0]            pending_o,
  output logic [N_SRC-1:0][N_SRC-1:0] older_o
);
  logic [N_SRC-1:0]            pend_q, pend_d;
  logic [N_SRC-1:0]            arrive;
  logic [N_SRC-1:0][N_SRC-1:0] older_q, older_d;

  // a source arrives when it is set, not yet pending and not withdrawn
  assign arrive = set_i & ~pend_q & ~clr_i;

  always_comb begin
    pend_d = (pend_q & ~clr_i & ~(ack_i & edge_i)) | arrive;
  end

  // older[r][c] = 1 means source r became pending before source c
  always_comb begin
    older_d = older_q;
    for (int r = 0; r < N_SRC; r++) begin
      for (int c = 0; c < N_SRC; c++) begin
        if (arrive[r] && arrive[c]) older_d[r][c] = (r < c);
        else if (arrive[c])         older_d[r][c] = 1'b1;
        else if (arrive[r])         older_d[r][c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      older_q <= '0;
    end else begin
      pend_q  <= pend_d;
      older_q <= older_d;
    end
  end

  assign pending_o = pend_q;
  assign older_o   = older_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    // R7
    edge_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && edge_i[g]) |=> !pending_o[g]);
    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[g] |=> !pending_o[g]);
    // R5
    set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o[g] && set_i[g] && !clr_i[g] && !(ack_i[g] && edge_i[g])) |=> pending_o[g]);
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 9
) (
  input  logic [N_SRC-1:0]            pending_i,
  input  logic [N_SRC-1:0][N_SRC-1:0] older_i,
  input  logic [LVL_W*N_SRC-1:0]      lvl_i,
  input  logic [VEC_W*N_SRC-1:0]      vec_i,
  input  lvl_t                        cur_pri_i,
  input  logic                        eval_i,
  output logic                        take_o,
  output logic [N_SRC-1:0]            ack_o,
  output logic [VEC_W-1:0]            vec_o,
  output lvl_t                        lvl_o
);
  lvl_t               src_lvl [N_SRC];
  logic [VEC_W-1:0]   src_vec [N_SRC];
  logic [NUM_LVL-1:0] lvl_busy;
  logic               found;
  lvl_t               best;
  logic [N_SRC-1:0]   cand, win;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_lvl[s] = lvl_i[s*LVL_W +: LVL_W];
    assign src_vec[s] = vec_i[s*VEC_W +: VEC_W];
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [N_SRC-1:0] at_lvl;
    for (genvar s = 0; s < N_SRC; s++) begin : g_m
      assign at_lvl[s] = pending_i[s] && (src_lvl[s] == lvl_t'(l));
    end
    assign lvl_busy[l] = |at_lvl;
  end

  // scan from the top level down to one above the processor priority
  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (!found && (l > int'(cur_pri_i)) && lvl_busy[l]) begin
        found = 1'b1;
        best  = lvl_t'(l);
      end
    end
  end

  // oldest pending source at the winning level
  always_comb begin
    for (int s = 0; s < N_SRC; s++) cand[s] = pending_i[s] && (src_lvl[s] == best);
    for (int s = 0; s < N_SRC; s++) begin
      win[s] = cand[s];
      for (int o = 0; o < N_SRC; o++) begin
        if (o != s && cand[o] && older_i[o][s]) win[s] = 1'b0;
      end
    end
  end

  assign take_o = eval_i && found;
  assign ack_o  = take_o ? win : '0;
  assign lvl_o  = best;

  always_comb begin
    vec_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (ack_o[s]) vec_o = vec_o | src_vec[s];
    end
  end
endmodule

// File: rtl/irq_cpu_ctl.sv
module irq_cpu_ctl
  import irq_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psw_wr_i,
  input  lvl_t        psw_pri_i,
  input  logic        op_valid_i,
  input  logic [15:0] opcode_i,
  input  logic        wait_req_i,
  input  logic        take_i,
  output lvl_t        cur_pri_o,
  output logic        waiting_o,
  output logic        wake_o
);
  lvl_t pri_q, pri_d;
  logic pri_en;
  logic wait_q, wait_d, wait_en;
  logic setpri;

  assign setpri = op_valid_i && is_setpri(opcode_i);
  assign pri_en = psw_wr_i || setpri;

  always_comb begin
    pri_d = pri_q;
    if (psw_wr_i)    pri_d = psw_pri_i;
    else if (setpri) pri_d = opcode_i[LVL_W-1:0];
  end

  assign wait_en = take_i || wait_req_i;
  assign wait_d  = !take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      if (pri_en)  pri_q  <= pri_d;
      if (wait_en) wait_q <= wait_d;
    end
  end

  assign cur_pri_o = pri_q;
  assign waiting_o = wait_q;
  assign wake_o    = take_i && wait_q;

  // R9
  setpri_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setpri && !psw_wr_i) |=> (cur_pri_o == $past(opcode_i[LVL_W-1:0])));
  // R9
  psw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr_i |=> (cur_pri_o == $past(psw_pri_i)));
  // R10
  take_unwait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !waiting_o);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       irq_set,
  input  logic [N_SRC-1:0]       irq_clr,
  input  logic [N_SRC-1:0]       irq_edge,
  input  logic [3*N_SRC-1:0]     irq_lvl,
  input  logic [VEC_W*N_SRC-1:0] irq_vec,
  input  logic                   boundary,
  input  logic                   cpu_halted,
  input  logic                   wait_req,
  input  logic                   psw_wr,
  input  logic [2:0]             psw_pri_wdata,
  input  logic                   op_valid,
  input  logic [15:0]            opcode,
  output logic                   take,
  output logic [VEC_W-1:0]       take_vec,
  output logic [2:0]             take_lvl,
  output logic [N_SRC-1:0]       irq_ack,
  output logic [2:0]             cur_pri,
  output logic                   waiting,
  output logic                   wake
);
  logic                        rst_n_s;
  logic [N_SRC-1:0]            pending;
  logic [N_SRC-1:0][N_SRC-1:0] older;
  logic                        eval;

  irq_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  irq_pend_order #(.N_SRC(N_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_i    (irq_set),
    .clr_i    (irq_clr),
    .ack_i    (irq_ack),
    .edge_i   (irq_edge),
    .pending_o(pending),
    .older_o  (older)
  );

  // a waiting core is re-examined every cycle, a running one at boundaries
  assign eval = !cpu_halted && (boundary || waiting);

  irq_level_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
    .pending_i(pending),
    .older_i  (older),
    .lvl_i    (irq_lvl),
    .vec_i    (irq_vec),
    .cur_pri_i(cur_pri),
    .eval_i   (eval),
    .take_o   (take),
    .ack_o    (irq_ack),
    .vec_o    (take_vec),
    .lvl_o    (take_lvl)
  );

  irq_cpu_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .psw_wr_i  (psw_wr),
    .psw_pri_i (psw_pri_wdata),
    .op_valid_i(op_valid),
    .opcode_i  (opcode),
    .wait_req_i(wait_req),
    .take_i    (take),
    .cur_pri_o (cur_pri),
    .waiting_o (waiting),
    .wake_o    (wake)
  );

  // R2
  take_halt_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    take |-> (!cpu_halted && (boundary || waiting)));
  // R3
  take_above_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    take |-> (take_lvl > cur_pri));
  // R8
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($onehot0(irq_ack) && (take == (irq_ack != '0))));
endmodule

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
  localparam int N = 8;
  localparam int VW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] set_r = '0, clr_r = '0, edge_r = '0;
  logic [2:0]   slvl [N];
  logic [VW-1:0] svec [N];
  logic [3*N-1:0]  lvl_p;
  logic [VW*N-1:0] vec_p;
  logic bnd = 0, halt = 0, wreq = 0, pwr = 0, opv = 0;
  logic [2:0]  pdat = '0;
  logic [15:0] op = '0;

  logic take, waiting, wake;
  logic [VW-1:0] take_vec;
  logic [2:0] take_lvl, cur_pri;
  logic [N-1:0] ack;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lvl_p[i*3 +: 3]   = slvl[i];
      vec_p[i*VW +: VW] = svec[i];
    end
  end

  irq_prio_arb #(.N_SRC(N), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_set(set_r), .irq_clr(clr_r), .irq_edge(edge_r),
    .irq_lvl(lvl_p), .irq_vec(vec_p), .boundary(bnd), .cpu_halted(halt),
    .wait_req(wreq), .psw_wr(pwr), .psw_pri_wdata(pdat), .op_valid(opv),
    .opcode(op), .take(take), .take_vec(take_vec), .take_lvl(take_lvl),
    .irq_ack(ack), .cur_pri(cur_pri), .waiting(waiting), .wake(wake)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model state
  bit mp [N];
  int unsigned ms [N];
  int unsigned stamp = 0;
  int mpri = 0;
  bit mwait = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick();
    int best = -1;
    if (halt || !(bnd || mwait)) return -1;
    for (int l = 7; l > mpri; l--) begin
      if (best < 0) begin
        for (int i = 0; i < N; i++)
          if (mp[i] && int'(slvl[i]) == l && (best < 0 || ms[i] < ms[best])) best = i;
      end
    end
    return best;
  endfunction

  // compare against the model, then advance the model across the coming edge
  task automatic model_step();
    int w;
    logic [N-1:0] eack;
    w = model_pick();
    eack = (w >= 0) ? (N'(1) << w) : '0;
    chk(take == (w >= 0), "R3 take", 32'(take), 32'(w >= 0));
    chk(ack == eack, "R8 ack", 32'(ack), 32'(eack));
    if (w >= 0) begin
      chk(take_vec == svec[w], "R8 vec", 32'(take_vec), 32'(svec[w]));
      chk(take_lvl == slvl[w], "R8 lvl", 32'(take_lvl), 32'(slvl[w]));
    end
    chk(int'(cur_pri) == mpri, "R9 pri", 32'(cur_pri), 32'(mpri));
    chk(waiting == mwait, "R10 waiting", 32'(waiting), 32'(mwait));
    chk(wake == ((w >= 0) && mwait), "R10 wake", 32'(wake), 32'((w >= 0) && mwait));
    for (int i = 0; i < N; i++) begin
      if (clr_r[i]) mp[i] = 0;
      else if (w == i && edge_r[i]) mp[i] = 0;
      else if (set_r[i] && !mp[i]) begin mp[i] = 1; ms[i] = stamp; stamp++; end
    end
    if (pwr) mpri = int'(pdat);
    else if (opv && op[15:3] == 13'h0013) mpri = int'(op[2:0]);
    if (w >= 0) mwait = 0;
    else if (wreq) mwait = 1;
  endtask

  task automatic finish_cyc();
    model_step();
    @(negedge clk);
    set_r = '0; clr_r = '0; bnd = 0; halt = 0; wreq = 0; pwr = 0; opv = 0; op = '0;
  endtask

  // a quiet cycle: drive nothing, check, advance
  task automatic idle(); #1; finish_cyc(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // directed configuration: index, level, edge
    for (int i = 0; i < N; i++) svec[i] = VW'(9'h040 + 4 * i);
    slvl[0] = 3'd2; slvl[1] = 3'd5; slvl[2] = 3'd5; slvl[3] = 3'd5;
    slvl[4] = 3'd7; slvl[5] = 3'd5; slvl[6] = 3'd1; slvl[7] = 3'd3;
    edge_r = 8'b0101_1110; // sources 1,2,3,4,6 edge-style; 0,5,7 level-style
    for (int i = 0; i < N; i++) begin mp[i] = 0; ms[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bnd = 1; #1;
    chk(take == 0 && ack == '0 && wake == 0, "R1 no take", 32'(take), 0);
    chk(cur_pri == 0 && waiting == 0, "R1 pri/wait", 32'({cur_pri, waiting}), 0);
    finish_cyc();

    // R4/R5: source 3 then 1 at level 5, then 3 re-asserted
    set_r[3] = 1; idle();
    set_r[1] = 1; idle();
    set_r[3] = 1; idle();
    bnd = 1; #1;
    chk(take && take_vec == svec[3], "R5 reassert keeps order", 32'(take_vec), 32'(svec[3]));
    finish_cyc();
    bnd = 1; #1;
    chk(take && take_vec == svec[1], "R7 edge source dropped on ack", 32'(take_vec), 32'(svec[1]));
    finish_cyc();
    // R4 simultaneous arrival at level 5: lower index first
    set_r[5] = 1; set_r[2] = 1; idle();
    bnd = 1; #1;
    chk(ack == 8'h04, "R4 same-cycle tie lower index", 32'(ack), 32'h04);
    finish_cyc();
    bnd = 1; #1;
    chk(ack == 8'h20, "R4 next oldest", 32'(ack), 32'h20);
    finish_cyc();
    bnd = 1; #1;
    chk(ack == 8'h20, "R7 level source stays pending", 32'(ack), 32'h20);
    clr_r[5] = 1; finish_cyc();
    bnd = 1; #1;
    chk(take == 0, "R6 withdrawn source gone", 32'(take), 0);
    finish_cyc();

    // R3: levels 2 and 3 pending, highest wins; priority gating
    set_r[0] = 1; set_r[7] = 1; idle();
    bnd = 1; opv = 1; op = 16'h009B; #1;
    chk(ack == 8'h80, "R3 highest level wins", 32'(ack), 32'h80);
    finish_cyc();
    bnd = 1; #1;
    chk(cur_pri == 3 && take == 0, "R3 level equal to priority held off", 32'({cur_pri, take}), 32'h6);
    finish_cyc();
    pwr = 1; pdat = 3'd1; opv = 1; op = 16'h009F; idle();
    bnd = 1; #1;
    chk(cur_pri == 1 && ack == 8'h80, "R9 status write beats opcode", 32'(cur_pri), 1);
    finish_cyc();
    pwr = 1; pdat = 3'd2; clr_r[7] = 1; idle();
    bnd = 1; #1;
    chk(take == 0, "R3 level 2 held at priority 2", 32'(take), 0);
    pwr = 1; pdat = 3'd1; finish_cyc();
    bnd = 1; #1;
    chk(ack == 8'h01, "R3 level 2 taken at priority 1", 32'(ack), 1);
    clr_r[0] = 1; finish_cyc();

    // R2: halted blocks, no boundary blocks
    set_r[4] = 1; idle();
    bnd = 1; halt = 1; #1;
    chk(take == 0, "R2 halted", 32'(take), 0);
    finish_cyc();
    #1; chk(take == 0, "R2 no boundary", 32'(take), 0); finish_cyc();
    bnd = 1; #1;
    chk(ack == 8'h10, "R2 boundary take", 32'(ack), 32'h10);
    finish_cyc();

    // R10: wait then wake without boundary
    wreq = 1; set_r[6] = 1; idle();
    #1; chk(waiting == 1 && take == 0, "R10 waiting, level 1 held", 32'({waiting, take}), 32'h2);
    finish_cyc();
    opv = 1; op = 16'h0098; idle();
    #1; chk(take && wake && ack == 8'h40, "R10 wake from wait", 32'({take, wake}), 32'h3);
    finish_cyc();
    #1; chk(waiting == 0, "R10 wait cleared", 32'(waiting), 0); finish_cyc();

    // R6: set and clear together
    set_r[1] = 1; clr_r[1] = 1; idle();
    bnd = 1; #1;
    chk(take == 0, "R6 clear wins over set", 32'(take), 0);
    finish_cyc();

    // constrained random phase
    void'($urandom(32'd4242));
    for (int blk = 0; blk < 10; blk++) begin
      clr_r = '1; idle();
      idle();
      for (int i = 0; i < N; i++) slvl[i] = 3'($urandom_range(0, 7));
      edge_r = N'($urandom);
      for (int c = 0; c < 400; c++) begin
        for (int i = 0; i < N; i++) begin
          set_r[i] = ($urandom_range(0, 7) == 0);
          clr_r[i] = ($urandom_range(0, 15) == 0);
        end
        bnd  = ($urandom_range(0, 1) == 0);
        halt = ($urandom_range(0, 9) == 0);
        wreq = ($urandom_range(0, 19) == 0);
        pwr  = ($urandom_range(0, 15) == 0);
        pdat = 3'($urandom_range(0, 7));
        opv  = ($urandom_range(0, 7) == 0);
        op   = ($urandom_range(0, 1) == 0) ? (16'h0098 | 16'($urandom_range(0, 7))) : 16'($urandom);
        idle();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule